// File: doc/BRIEF.md
# Receive Byte Queue with Programmable Trigger Level

This block buffers bytes delivered by a serial receiver's deserialiser until software collects them. In queued mode it stores up to sixteen bytes in arrival order and raises a trigger flag once the number of stored bytes reaches one of four selectable thresholds. An interrupt controller would use this flag to decide when to interrupt. In direct mode it behaves as a single-byte holding register.

A small control register sets the mode and the threshold. Two of its bits are command bits: writing them requests an empty queue, and they never read back as set. When the queue is full, one additional byte can wait in the receiver's shift stage. A byte that arrives while that stage is still occupied is lost and raises a sticky overrun flag. A read of the line status clears that flag.

Top module: `rxq_trig`

## Requirements
- R1: After reset, data_ready, trig_hit, overrun and fifo_on are 0, and ctl_rdata is 0x00.
- R2: A control write stores bit 0 as the queued-mode enable and bits 7:6 as the threshold code. ctl_rdata returns {code, 5'b00000, enable}, so bits 1 and 2 always read 0 and a write of 0xC7 reads back as 0xC1. fifo_on equals the stored enable.
- R3: A control write with bit 1 set, or one whose bit 0 differs from the stored enable, empties the queue and the shift-stage byte. A byte that arrives in that same cycle is discarded. The overrun flag is not changed by the flush.
- R4: In queued mode, trig_hit is 1 while the stored count is at least 1, 4, 8 or 14 for codes 00, 01, 10 or 11. In direct mode, trig_hit equals data_ready.
- R5: data_ready is 1 exactly when at least one byte is stored.
- R6: Bytes leave in arrival order. head_byte shows the oldest stored byte whenever data_ready is 1, and a read strobe removes it.
- R7: In queued mode the queue holds 16 bytes, and a 17th byte waits in the shift stage without setting overrun. A read in a cycle when the shift stage is occupied moves the waiting byte into the queue in that same cycle.
- R8: In queued mode, a byte that arrives while 16 bytes are stored, the shift stage is occupied and no read is made replaces the waiting byte and sets overrun.
- R9: In direct mode one byte is stored. A new byte that arrives while that byte is unread, with no read in the same cycle, sets overrun and leaves the older byte on head_byte.
- R10: A line status read clears overrun on the next edge, unless an overrun event occurs in the same cycle, in which case overrun stays set.
- R11: A control write that changes only the threshold code leaves the stored bytes and their order intact.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_valid | input | 1 | One-cycle strobe: a received byte is present |
| rx_byte | input | 8 | Received byte |
| rd_pop | input | 1 | Receive buffer read strobe; removes the head byte |
| ctl_we | input | 1 | Control register write strobe |
| ctl_wdata | input | 8 | Control register write data |
| lsr_rd | input | 1 | Line status read strobe; clears overrun |
| head_byte | output | 8 | Oldest stored byte |
| data_ready | output | 1 | At least one byte stored |
| trig_hit | output | 1 | Stored count has reached the threshold |
| overrun | output | 1 | Sticky overrun error flag |
| fifo_on | output | 1 | Queued mode enabled |
| ctl_rdata | output | 8 | Control register read-back |

## Verification
The hardest situation to reach from the ports is the one where the queue holds sixteen bytes, the shift stage is occupied, and either a read or a further arrival lands in the same cycle. That case separates a legal hold from a lost byte. A directed burst of eighteen arrivals with no reads gets there: one read then checks the same-cycle transfer, and the bytes drained afterwards show that the replacing byte comes out last. Random phases with heavy arrivals and rare reads revisit this state repeatedly, with mode, threshold and flush writes mixed in.

// File: rtl/rxq_pkg.sv
package rxq_pkg;

    typedef enum logic [1:0] {
        TRIG_ONE  = 2'b00,
        TRIG_QTR  = 2'b01,
        TRIG_HALF = 2'b10,
        TRIG_NEAR = 2'b11
    } trig_sel_e;

    typedef struct packed {
        trig_sel_e sel;
        logic      en;
    } rxq_cfg_t;

    // Threshold in entries for a queue of the given depth.
    function automatic int unsigned trig_count(trig_sel_e s, int unsigned depth);
        case (s)
            TRIG_ONE:  return 1;
            TRIG_QTR:  return depth / 4;
            TRIG_HALF: return depth / 2;
            default:   return depth - 2;
        endcase
    endfunction

endpackage

// File: rtl/rxq_ctl.sv
module rxq_ctl
    import rxq_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       we,
    input  logic [7:0] wdata,
    output rxq_cfg_t   cfg,
    output logic       flush,
    output logic [7:0] rdata
);
    // Explicit empty request, or a change of mode.
    assign flush = we && (wdata[1] || (wdata[0] != cfg.en));
    assign rdata = {cfg.sel, 5'b00000, cfg.en};

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg <= '{sel: TRIG_ONE, en: 1'b0};
        end else if (we) begin
            cfg <= '{sel: trig_sel_e'(wdata[7:6]), en: wdata[0]};
        end
    end
endmodule

// File: rtl/rxq_store.sv
module rxq_store #(
    parameter int DEPTH = 16,
    parameter int W     = 8,
    localparam int AW   = $clog2(DEPTH),
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          flush,
    input  logic          fifo_on,
    input  logic          rx_valid,
    input  logic [W-1:0]  rx_data,
    input  logic          pop_req,
    output logic [W-1:0]  head,
    output logic [CW-1:0] cnt,
    output logic          lost
);
    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] wptr, rptr;
    logic          hold_vld, hold_n;
    logic [W-1:0]  hold_q, hold_dn;
    logic          push, pop, full;
    logic [W-1:0]  push_d;
    logic [CW-1:0] cap;

    function automatic logic [AW-1:0] nxt(logic [AW-1:0] p);
        return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    always_comb begin
        cap     = fifo_on ? CW'(DEPTH) : CW'(1);
        pop     = pop_req && (cnt != '0);
        full    = (cnt >= cap);
        push    = 1'b0;
        push_d  = rx_data;
        hold_n  = hold_vld;
        hold_dn = hold_q;
        lost    = 1'b0;
        if (fifo_on && hold_vld) begin
            if (pop) begin
                push    = 1'b1;
                push_d  = hold_q;
                hold_n  = rx_valid;
                hold_dn = rx_data;
            end else if (rx_valid) begin
                hold_dn = rx_data;
                lost    = 1'b1;
            end
        end else if (rx_valid) begin
            if (!full || pop) begin
                push = 1'b1;
            end else if (fifo_on) begin
                hold_n  = 1'b1;
                hold_dn = rx_data;
            end else begin
                lost = 1'b1;
            end
        end
        if (flush) begin
            push = 1'b0;
            lost = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst || flush) begin
            wptr     <= '0;
            rptr     <= '0;
            cnt      <= '0;
            hold_vld <= 1'b0;
            hold_q   <= '0;
        end else begin
            if (push) wptr <= nxt(wptr);
            if (pop)  rptr <= nxt(rptr);
            cnt      <= cnt + CW'(push) - CW'(pop);
            hold_vld <= hold_n;
            hold_q   <= hold_dn;
        end
    end

    always_ff @(posedge clk) begin
        if (push) mem[wptr] <= push_d;
    end

    assign head = mem[rptr];
endmodule

// File: rtl/rxq_flags.sv
module rxq_flags
    import rxq_pkg::*;
#(
    parameter int DEPTH = 16,
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          lost,
    input  logic          lsr_rd,
    input  logic [CW-1:0] cnt,
    input  rxq_cfg_t      cfg,
    output logic          overrun,
    output logic          trig
);
    logic [CW-1:0] level;

    always_comb begin
        level = CW'(trig_count(cfg.sel, DEPTH));
        trig  = cfg.en ? (cnt >= level) : (cnt != '0);
    end

    always_ff @(posedge clk) begin
        if (rst)         overrun <= 1'b0;
        else if (lost)   overrun <= 1'b1;
        else if (lsr_rd) overrun <= 1'b0;
    end
endmodule

// File: rtl/rxq_trig.sv
module rxq_trig
    import rxq_pkg::*;
#(
    parameter int DEPTH = 16,
    parameter int W     = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         rx_valid,
    input  logic [W-1:0] rx_byte,
    input  logic         rd_pop,
    input  logic         ctl_we,
    input  logic [7:0]   ctl_wdata,
    input  logic         lsr_rd,
    output logic [W-1:0] head_byte,
    output logic         data_ready,
    output logic         trig_hit,
    output logic         overrun,
    output logic         fifo_on,
    output logic [7:0]   ctl_rdata
);
    localparam int CW = $clog2(DEPTH + 1);

    rxq_cfg_t      cfg;
    logic          flush, lost;
    logic [CW-1:0] cnt;

    rxq_ctl u_ctl (
        .clk(clk), .rst(rst), .we(ctl_we), .wdata(ctl_wdata),
        .cfg(cfg), .flush(flush), .rdata(ctl_rdata)
    );

    rxq_store #(.DEPTH(DEPTH), .W(W)) u_store (
        .clk(clk), .rst(rst), .flush(flush), .fifo_on(cfg.en),
        .rx_valid(rx_valid), .rx_data(rx_byte), .pop_req(rd_pop),
        .head(head_byte), .cnt(cnt), .lost(lost)
    );

    rxq_flags #(.DEPTH(DEPTH)) u_flags (
        .clk(clk), .rst(rst), .lost(lost), .lsr_rd(lsr_rd),
        .cnt(cnt), .cfg(cfg), .overrun(overrun), .trig(trig_hit)
    );

    assign data_ready = (cnt != '0);
    assign fifo_on    = cfg.en;
endmodule

// File: rtl/rxq_trig_chk.sv
module rxq_trig_chk #(
    parameter int DEPTH = 16,
    parameter int W     = 8,
    parameter int CW    = 5
) (
    input logic          clk,
    input logic          rst,
    input logic          rx_valid,
    input logic          rd_pop,
    input logic          ctl_we,
    input logic [7:0]    ctl_wdata,
    input logic          lsr_rd,
    input logic [W-1:0]  head_byte,
    input logic          data_ready,
    input logic          overrun,
    input logic          fifo_on,
    input logic [7:0]    ctl_rdata,
    input logic [CW-1:0] cnt
);
    // R7
    depth_cap_chk: assert property (@(posedge clk) disable iff (rst)
        cnt <= CW'(DEPTH));

    // R9
    single_slot_chk: assert property (@(posedge clk) disable iff (rst)
        !fifo_on |-> cnt <= CW'(1));

    // R3
    flush_empty_chk: assert property (@(posedge clk) disable iff (rst)
        (ctl_we && ctl_wdata[1]) |=> !data_ready);

    // R10
    ovr_clear_chk: assert property (@(posedge clk) disable iff (rst)
        (lsr_rd && !rx_valid) |=> !overrun);

    // R9
    keep_old_chk: assert property (@(posedge clk) disable iff (rst)
        (!fifo_on && data_ready && rx_valid && !rd_pop && !ctl_we)
        |=> (overrun && $stable(head_byte)));

    // R2
    ctl_readback_chk: assert property (@(posedge clk) disable iff (rst)
        ctl_we |=> (ctl_rdata[5:1] == 5'b0
                    && ctl_rdata[0] == $past(ctl_wdata[0])
                    && ctl_rdata[7:6] == $past(ctl_wdata[7:6])));
endmodule

bind rxq_trig rxq_trig_chk #(.DEPTH(DEPTH), .W(W), .CW(CW)) u_chk (
    .clk(clk), .rst(rst), .rx_valid(rx_valid), .rd_pop(rd_pop),
    .ctl_we(ctl_we), .ctl_wdata(ctl_wdata), .lsr_rd(lsr_rd),
    .head_byte(head_byte), .data_ready(data_ready), .overrun(overrun),
    .fifo_on(fifo_on), .ctl_rdata(ctl_rdata), .cnt(cnt)
);

// File: tb/test_rxq_trig.sv
`timescale 1ns/1ps
module test_rxq_trig;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       rx_valid = 1'b0, rd_pop = 1'b0, ctl_we = 1'b0, lsr_rd = 1'b0;
    logic [7:0] rx_byte = '0, ctl_wdata = '0;
    logic [7:0] head_byte, ctl_rdata;
    logic       data_ready, trig_hit, overrun, fifo_on;

    always #2.5 clk = ~clk;

    rxq_trig i_rxq_trig (
        .clk(clk), .rst(rst), .rx_valid(rx_valid), .rx_byte(rx_byte),
        .rd_pop(rd_pop), .ctl_we(ctl_we), .ctl_wdata(ctl_wdata), .lsr_rd(lsr_rd),
        .head_byte(head_byte), .data_ready(data_ready), .trig_hit(trig_hit),
        .overrun(overrun), .fifo_on(fifo_on), .ctl_rdata(ctl_rdata)
    );

    int total = 0, fails = 0;
    logic [7:0] q[$];
    bit         m_hold = 0, m_ov = 0, m_en = 0;
    logic [7:0] m_holdb = 0;
    bit   [1:0] m_sel = 0;

    function automatic int lvl(bit [1:0] s);
        case (s) 2'd0: return 1; 2'd1: return 4; 2'd2: return 8; default: return 14; endcase
    endfunction

    task automatic chk(bit ok, string tag, int act, int exp);
        total++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h at %0t", tag, act, exp, $time);
        end
    endtask

    // Reference behaviour for one edge.
    task automatic model(bit rxv, logic [7:0] rxb, bit pop, bit we, logic [7:0] wd, bit lsr);
        bit lost = 0, popd;
        if (we && (wd[1] || wd[0] != m_en)) begin
            q.delete(); m_hold = 0;
        end else begin
            popd = pop && q.size() > 0;
            if (m_en && m_hold) begin
                if (popd) begin
                    void'(q.pop_front()); q.push_back(m_holdb);
                    m_hold = rxv; m_holdb = rxb;
                end else if (rxv) begin
                    m_holdb = rxb; lost = 1;
                end
            end else begin
                if (popd) void'(q.pop_front());
                if (rxv) begin
                    if (q.size() < (m_en ? 16 : 1)) q.push_back(rxb);
                    else if (m_en) begin m_hold = 1; m_holdb = rxb; end
                    else lost = 1;
                end
            end
        end
        if (we) begin m_en = wd[0]; m_sel = wd[7:6]; end
        if (lost) m_ov = 1; else if (lsr) m_ov = 0;
    endtask

    task automatic compare();
        bit exp_trig = m_en ? (q.size() >= lvl(m_sel)) : (q.size() > 0);
        // R5
        chk(data_ready == (q.size() > 0), "R5", data_ready, q.size() > 0);
        // R6
        if (q.size() > 0) chk(head_byte == q[0], "R6", head_byte, q[0]);
        // R4
        chk(trig_hit == exp_trig, "R4", trig_hit, exp_trig);
        // R10
        chk(overrun == m_ov, "R10", overrun, m_ov);
        // R2
        chk(ctl_rdata == {m_sel, 5'b0, m_en} && fifo_on == m_en, "R2",
            ctl_rdata, {m_sel, 5'b0, m_en});
    endtask

    task automatic cyc(bit rxv, logic [7:0] rxb, bit pop, bit we, logic [7:0] wd, bit lsr);
        @(negedge clk);
        rx_valid = rxv; rx_byte = rxb; rd_pop = pop; ctl_we = we; ctl_wdata = wd; lsr_rd = lsr;
        @(posedge clk); #1;
        model(rxv, rxb, pop, we, wd, lsr);
        compare();
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", total - fails, total);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++; total++;
        $display("FAIL watchdog: actual hung expected done");
        summary();
        $finish;
    end

    initial begin
        void'($urandom(32'd7741));
        repeat (3) @(posedge clk);
        @(negedge clk); rst = 1'b0;
        #1;
        // R1
        chk({data_ready, trig_hit, overrun, fifo_on} == 4'b0 && ctl_rdata == 8'h00,
            "R1", {data_ready, trig_hit, overrun, fifo_on, ctl_rdata}, 0);

        // R2: 0xC7 reads back as 0xC1
        cyc(0, 0, 0, 1, 8'hC7, 0);
        chk(ctl_rdata == 8'hC1, "R2", ctl_rdata, 8'hC1);

        for (int i = 0; i < 16; i++) cyc(1, 8'h10 + 8'(i), 0, 0, 0, 0);
        // R4: 16 >= 14
        chk(trig_hit == 1'b1, "R4", trig_hit, 1);
        cyc(1, 8'h40, 0, 0, 0, 0);
        // R7: 17th byte waits, no overrun
        chk(overrun == 1'b0, "R7", overrun, 0);
        cyc(1, 8'h41, 0, 0, 0, 0);
        // R8
        chk(overrun == 1'b1, "R8", overrun, 1);
        cyc(0, 0, 0, 0, 0, 1);
        // R10
        chk(overrun == 1'b0, "R10", overrun, 0);
        cyc(0, 0, 1, 0, 0, 0);
        // R6
        chk(head_byte == 8'h11, "R6", head_byte, 8'h11);
        cyc(0, 0, 0, 1, 8'h41, 0);
        // R11: threshold change keeps contents
        chk(head_byte == 8'h11 && data_ready, "R11", head_byte, 8'h11);
        for (int i = 0; i < 15; i++) cyc(0, 0, 1, 0, 0, 0);
        // R7: waiting byte entered on the read, now last
        chk(head_byte == 8'h41 && data_ready, "R7", head_byte, 8'h41);

        cyc(0, 0, 0, 1, 8'h00, 0);
        // R3: mode change empties
        chk(data_ready == 1'b0 && fifo_on == 1'b0, "R3", data_ready, 0);
        cyc(1, 8'hA5, 0, 0, 0, 0);
        cyc(1, 8'h5A, 0, 0, 0, 0);
        // R9
        chk(overrun == 1'b1 && head_byte == 8'hA5, "R9", head_byte, 8'hA5);
        cyc(1, 8'h77, 0, 1, 8'h07, 1);
        // R3: arrival during flush discarded
        chk(data_ready == 1'b0, "R3", data_ready, 0);

        for (int ph = 0; ph < 6; ph++) begin
            int prx = (ph % 2 == 0) ? 85 : 40;
            int ppop = (ph % 2 == 0) ? 8 : 55;
            for (int n = 0; n < 500; n++) begin
                bit we = ($urandom % 100) < 2;
                logic [7:0] wd = {2'($urandom), 5'b0, 1'(($urandom % 10) != 0)};
                if (($urandom % 8) == 0) wd[1] = 1'b1;
                cyc(($urandom % 100) < prx, 8'($urandom), ($urandom % 100) < ppop,
                    we, wd, ($urandom % 10) == 0);
            end
        end

        summary();
        $finish;
    end
endmodule